// File: doc/BRIEF.md
# Extended Program-Memory Byte Load Unit

This block carries out the three byte-load-from-program-memory instructions of an 8-bit microcontroller core when program memory holds more than 64 KB. It receives a 16-bit opcode with a start strobe and decodes it into one of three forms. The first form writes to a fixed destination register. The second form writes to a chosen register and leaves the pointer alone. The third form writes to a chosen register and then steps the pointer by one.

The byte address joins a page-select register, as the upper bits, with the 16-bit Z pointer, as the lower bits. The core's register file supplies the Z pointer and the page value at the moment of start. The unit reads one byte through a synchronous program-memory port with one cycle of latency. It then returns that byte, and any pointer update, through write ports back to the register file. Every accepted instruction takes exactly three cycles.

An opcode outside the three forms is refused. It produces a one-cycle illegal flag and has no other effect.

Top module: `xload_unit`

## Requirements
- R1: Opcode 16'h95D8 selects the fixed form: the loaded byte is written to register index 0, and neither Z nor the page register is written.
- R2: An opcode where (opcode & 16'hFE0F) == 16'h9006 selects the plain register form: the byte is written to the register index held in opcode bits [8:4], and Z and the page register are not written.
- R3: An opcode where (opcode & 16'hFE0F) == 16'h9007 selects the stepping form: the byte is written to the register index in opcode bits [8:4], and in the same cycle z_wdata carries the start-time Z plus one (modulo 2^16) with z_we high.
- R4: The memory address is {page mod NUM_PAGES, Z}, with Z = {zhi_rd, zlo_rd} captured at start. It is driven with mem_rd high in the first cycle after start only. The byte written back is the one the memory returns for that address.
- R5: In the stepping form with Z == 16'hFFFF, Z becomes 0, page_we pulses with page_wdata = (page + 1) mod NUM_PAGES (for example 3 becomes 0 with four pages), and page_we stays low for every other Z.
- R6: An accepted opcode keeps busy high for exactly three cycles after the start edge. done, rf_we, z_we and page_we can only be high in the third of these cycles.
- R7: A start with any other opcode raises illegal for exactly one cycle after the start edge, keeps busy low, and produces no memory read and no register write.
- R8: A start pulse while busy is ignored: it neither raises illegal nor changes the running instruction's address, destination or results.
- R9: After a synchronous active-low reset, busy, done, illegal, mem_rd, rf_we, z_we and page_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Opcode valid strobe, sampled while idle |
| opcode | input | 16 | Instruction word |
| zlo_rd | input | 8 | Register file value of the Z low byte (r30) |
| zhi_rd | input | 8 | Register file value of the Z high byte (r31) |
| page_rd | input | 8 | Register file value of the page-select register |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of an instruction |
| illegal | output | 1 | One-cycle flag for a refused opcode |
| mem_rd | output | 1 | Program-memory read enable |
| mem_addr | output | 16+PAGE_W | Program-memory byte address |
| mem_rdata | input | 8 | Program-memory read data, one cycle after mem_rd |
| rf_we | output | 1 | Destination register write enable |
| rf_waddr | output | 5 | Destination register index |
| rf_wdata | output | 8 | Loaded byte |
| z_we | output | 1 | Z pair write enable |
| z_wdata | output | 16 | New Z value (low byte to r30, high byte to r31) |
| page_we | output | 1 | Page-select register write enable |
| page_wdata | output | 8 | New page-select value |

## Verification
A wrongly latched pointer or page shows on mem_addr in the first cycle after start, one cycle before any write. A wrong decode shows as a wrong rf_waddr, or as a stray z_we, in the third cycle. A wrong carry or wrap shows only when Z was 16'hFFFF, on page_we and page_wdata in that same third cycle. The bench therefore sweeps every opcode in a 2048-word window around the encodings with varied pointers, and runs every page value through the carry case, so that each such fault appears within the op that triggers it.

// File: rtl/xload_pkg.sv
// Shared types for the extended program-memory byte load unit.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package xload_pkg;
    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_FIX  = 2'd1,
        FORM_REG  = 2'd2,
        FORM_STEP = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_CAPT   = 2'd2,
        ST_COMMIT = 2'd3
    } state_e;

    localparam logic [15:0] OPC_FIX      = 16'h95D8;
    localparam logic [15:0] OPC_FAM_MASK = 16'hFE0F;
    localparam logic [15:0] OPC_REG      = 16'h9006;
    localparam logic [15:0] OPC_STEP     = 16'h9007;
endpackage

// File: rtl/xload_decode.sv
// Opcode classifier: maps a 16-bit word onto one of the three load forms
// and extracts the destination register index.
// Assumes the caller qualifies the result with its own strobe.
module xload_decode
    import xload_pkg::*;
(
    input  logic [15:0] opcode,
    output form_e       form,
    output logic [4:0]  dest
);
    // Pick the form; the fixed form overrides the field-encoded destination.
    always_comb begin
        form = FORM_NONE;
        dest = opcode[8:4];
        if (opcode == OPC_FIX) begin
            form = FORM_FIX;
            dest = 5'd0;
        end else if ((opcode & OPC_FAM_MASK) == OPC_REG) begin
            form = FORM_REG;
        end else if ((opcode & OPC_FAM_MASK) == OPC_STEP) begin
            form = FORM_STEP;
        end
    end
endmodule

// File: rtl/xload_ptr.sv
// Pointer stepper: adds one to Z and carries into the page field, which
// wraps modulo NUM_PAGES. Assumes NUM_PAGES is a power of two, so the
// wrap is the natural overflow of a PAGE_W-bit field.
module xload_ptr #(
    parameter int NUM_PAGES = 4,
    parameter int PAGE_W    = 2
) (
    input  logic [15:0]       z,
    input  logic [PAGE_W-1:0] page,
    output logic [15:0]       z_inc,
    output logic [PAGE_W-1:0] page_inc,
    output logic              carry
);
    // Step Z and report the carry out of bit 15.
    always_comb begin
        {carry, z_inc} = {1'b0, z} + 17'd1;
    end

    generate
        if (NUM_PAGES == 1) begin : g_single
            // A single page never advances.
            always_comb page_inc = '0;
        end else begin : g_multi
            // Advance the page on carry; PAGE_W-bit overflow is the wrap.
            always_comb page_inc = carry ? page + 1'b1 : page;
        end
    endgenerate
endmodule

// File: rtl/xload_unit.sv
// Extended program-memory byte load unit (top).
// Accepts an opcode on start while idle, addresses program memory with
// {page, Z} one cycle later, captures the byte a cycle after that, and
// commits register, Z and page writes in the third cycle.
// Assumes a memory with exactly one cycle of read latency and a register
// file that applies the write ports on the clock edge ending the third cycle.
module xload_unit
    import xload_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    localparam int PAGE_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int ADDR_W   = 16 + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       opcode,
    input  logic [7:0]        zlo_rd,
    input  logic [7:0]        zhi_rd,
    input  logic [7:0]        page_rd,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              rf_we,
    output logic [4:0]        rf_waddr,
    output logic [7:0]        rf_wdata,
    output logic              z_we,
    output logic [15:0]       z_wdata,
    output logic              page_we,
    output logic [7:0]        page_wdata
);
    localparam logic [PAGE_W-1:0] PAGE_MASK = PAGE_W'(NUM_PAGES - 1);

    state_e            state_q;
    form_e             form_q;
    form_e             form_dec;
    logic [4:0]        dest_dec;
    logic [4:0]        dest_q;
    logic [15:0]       z_q;
    logic [PAGE_W-1:0] page_q;
    logic [7:0]        data_q;
    logic              illegal_q;
    logic [15:0]       z_inc;
    logic [PAGE_W-1:0] page_inc;
    logic              carry;

    xload_decode u_decode (
        .opcode (opcode),
        .form   (form_dec),
        .dest   (dest_dec)
    );

    xload_ptr #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) u_ptr (
        .z        (z_q),
        .page     (page_q),
        .z_inc    (z_inc),
        .page_inc (page_inc),
        .carry    (carry)
    );

    // Sequence the three cycles and latch operands on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            form_q  <= FORM_NONE;
            dest_q  <= '0;
            z_q     <= '0;
            page_q  <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start && form_dec != FORM_NONE) begin
                        form_q  <= form_dec;
                        dest_q  <= dest_dec;
                        z_q     <= {zhi_rd, zlo_rd};
                        page_q  <= page_rd[PAGE_W-1:0] & PAGE_MASK;
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR:   state_q <= ST_CAPT;
                ST_CAPT: begin
                    data_q  <= mem_rdata;
                    state_q <= ST_COMMIT;
                end
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Flag a refused opcode for the cycle after its start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= (state_q == ST_IDLE) && start && (form_dec == FORM_NONE);
    end

    // Drive the memory, status and write-back ports from the current state.
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_COMMIT);
        illegal    = illegal_q;
        mem_rd     = (state_q == ST_ADDR);
        mem_addr   = {page_q, z_q};
        rf_we      = done;
        rf_waddr   = dest_q;
        rf_wdata   = data_q;
        z_we       = done && (form_q == FORM_STEP);
        z_wdata    = z_inc;
        page_we    = z_we && carry;
        page_wdata = 8'(page_inc);
    end

    // R6
    commit_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state_q == ST_CAPT));
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    read_then_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (state_q == ST_CAPT) && !mem_rd);
    // R5
    page_only_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_we |-> z_we && (z_wdata == 16'h0000));
    // R7
    illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !busy && !rf_we && !mem_rd);
    // R8
    operands_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(dest_q) && $stable(z_q) && $stable(page_q));
    // R3
    step_only_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z_we |-> rf_we && (form_q == FORM_STEP));
endmodule

// File: tb/xload_unit_bench.sv
module xload_unit_bench;
    localparam int NP     = 4;
    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [15:0]       opcode = '0;
    logic [7:0]        zlo_rd = '0, zhi_rd = '0, page_rd = '0;
    logic              busy, done, illegal, mem_rd, rf_we, z_we, page_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_rdata = '0;
    logic [4:0]        rf_waddr;
    logic [7:0]        rf_wdata, page_wdata;
    logic [15:0]       z_wdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xload_unit #(.NUM_PAGES(NP)) u_xload_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .zlo_rd(zlo_rd), .zhi_rd(zhi_rd), .page_rd(page_rd),
        .busy(busy), .done(done), .illegal(illegal),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .z_we(z_we), .z_wdata(z_wdata), .page_we(page_we), .page_wdata(page_wdata)
    );

    function automatic logic [7:0] mdat(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ (8'(a[17:16]) * 8'd37);
    endfunction

    // Synchronous memory model, one cycle of latency.
    always @(posedge clk) if (mem_rd) mem_rdata <= mdat(mem_addr);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Run one opcode; poke=1 issues a second start while busy.
    task automatic run_op(input logic [15:0] op, input logic [15:0] z,
                          input logic [7:0] pg, input bit poke);
        int  form;
        int  dst;
        int  pgm;
        logic [ADDR_W-1:0] ea;
        logic [15:0] zn;
        form = 0;
        dst  = int'(op[8:4]);
        if (op == 16'h95D8) begin form = 1; dst = 0; end
        else if ((op & 16'hFE0F) == 16'h9006) form = 2;
        else if ((op & 16'hFE0F) == 16'h9007) form = 3;
        pgm = int'(pg) % NP;
        ea  = {2'(pgm), z};
        zn  = z + 16'd1;

        @(negedge clk);
        opcode = op; zlo_rd = z[7:0]; zhi_rd = z[15:8]; page_rd = pg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (form == 0) begin
            chk(illegal == 1'b1, "R7 illegal", int'(illegal), 1);
            chk(!busy && !mem_rd && !rf_we && !z_we && !page_we, "R7 no effect",
                int'({busy, mem_rd, rf_we, z_we, page_we}), 0);
            @(negedge clk);
            chk(illegal == 1'b0, "R7 one cycle", int'(illegal), 0);
            return;
        end
        chk(busy && mem_rd && !done, "R6 cycle1", int'({busy, mem_rd, done}), 6);
        chk(mem_addr == ea, "R4 address", int'(mem_addr), int'(ea));
        if (poke) begin
            opcode = 16'h0000; zlo_rd = ~z[7:0]; zhi_rd = ~z[15:8]; page_rd = pg + 8'd1;
            start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        chk(busy && !mem_rd && !done && !rf_we, "R6 cycle2",
            int'({busy, mem_rd, done, rf_we}), 8);
        if (poke) chk(illegal == 1'b0, "R8 no illegal", int'(illegal), 0);
        @(negedge clk);
        chk(busy && done && rf_we, "R6 cycle3", int'({busy, done, rf_we}), 7);
        chk(rf_waddr == 5'(dst), form == 1 ? "R1 dest" : "R2 dest", int'(rf_waddr), dst);
        chk(rf_wdata == mdat(ea), poke ? "R8 data" : "R4 data", int'(rf_wdata), int'(mdat(ea)));
        if (form == 3) begin
            chk(z_we && z_wdata == zn, "R3 z step", int'(z_wdata), int'(zn));
            if (z == 16'hFFFF) begin
                chk(page_we && page_wdata == 8'((pgm + 1) % NP), "R5 page wrap",
                    int'(page_wdata), (pgm + 1) % NP);
            end else begin
                chk(!page_we, "R5 no page write", int'(page_we), 0);
            end
        end else begin
            chk(!z_we && !page_we, form == 1 ? "R1 no z" : "R2 no z",
                int'({z_we, page_we}), 0);
        end
        @(negedge clk);
        chk(!busy && !done && !rf_we, "R6 idle after", int'({busy, done, rf_we}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, done, illegal, mem_rd, rf_we, z_we, page_we} == 7'd0, "R9 reset",
            int'({busy, done, illegal, mem_rd, rf_we, z_we, page_we}), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R7: sweep the opcode window around the encodings.
        for (int i = 16'h9000; i < 16'h9800; i++) begin
            run_op(16'(i), 16'(i * 16'h1357), 8'(i >> 3), 1'b0);
        end
        // R7: scattered opcodes across the rest of the space.
        for (int i = 0; i < 256; i++) begin
            run_op(16'((i * 257) ^ 16'h3C5A), 16'(i), 8'(i), 1'b0);
        end
        // R5: carry and near-carry pointers on every page value.
        for (int p = 0; p < 8; p++) begin
            run_op(16'h9057, 16'hFFFF, 8'(p), 1'b0);
            run_op(16'h90F7, 16'hFFFE, 8'(p), 1'b0);
            run_op(16'h9117, 16'h0000, 8'(p), 1'b0);
            run_op(16'h9066, 16'hFFFF, 8'(p), 1'b0);
            run_op(16'h95D8, 16'hFFFF, 8'(p), 1'b0);
        end
        // R4: the worked example, page 2 and Z 0x0050.
        run_op(16'h95D8, 16'h0050, 8'd2, 1'b0);
        // R8: starts while busy in each form.
        run_op(16'h95D8, 16'h1234, 8'd1, 1'b1);
        run_op(16'h9156, 16'hABCD, 8'd3, 1'b1);
        run_op(16'h9067, 16'hFFFF, 8'd3, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule